// File: doc/BRIEF.md
# Serial Word Memory Host Sequencer

This block sits on the host side of a three-wire serial memory that stores 16-bit words. A client hands it one operation at a time through a request/acknowledge pair: read a word, write a word, enable writes or disable writes. For each operation the sequencer builds the framed bit stream and drives the select line and a serial clock divided down from the system clock. It shifts read data back in and reports completion with a one-cycle done pulse.

The target powers up refusing writes. The sequencer keeps its own copy of that permission so that a write it knows would be dropped never reaches the wires. After each write frame it deselects and reselects the target, then samples the data-out line until the target reports ready. It then raises data-in so the target lets go of data-out, and only then signals done. Clock phase length and minimum deselect time are parameters, so the same block meets the serial timing limits for any system clock rate.

Top module: `wordmem_host`

## Requirements
- R1: Every frame is the lead pattern 1010, then a 4-bit opcode (read 1000, write 0100, enable 0011, disable 0000), then an 8-bit address field holding the ADDR_W address bits MSB first in its upper bits with zeros below. A write appends 16 data bits MSB first. Read and write frames last 32 serial clocks; enable and disable frames last 16.
- R2: `sclk` idles low, and each high and each low phase inside a frame lasts HALF_CYC system cycles. With the defaults at a 50 MHz clock this gives phases of at least 400 ns and a period of at least 1000 ns.
- R3: `mosi` changes only while `sclk` is low, never on a cycle where `sclk` is high.
- R4: `cs_n` stays high for at least CSH_CYC system cycles before every fall (250 ns with defaults), and `sclk` is low whenever `cs_n` is high.
- R5: For a read, `miso` is sampled on the rising clocks 17 to 32, MSB first. The word is presented on `rd_data` in the cycle `done` is high.
- R6: `wr_enabled` is 0 after reset. It becomes 1 after an enable operation completes and 0 after a disable completes, and it changes only in the cycle after a `done` pulse.
- R7: A write requested while `wr_enabled` is 0 sends nothing: `cs_n` stays high, and `done` and `done_rej` are both high one cycle after acceptance. The target's contents are left untouched.
- R8: After a write frame the sequencer deselects for CSH_CYC cycles and reselects without clocking. It samples `miso` once per HALF_CYC cycles, reads 0 as busy and 1 as ready, and raises `done` only after a 1 is seen.
- R9: Once ready is seen, `mosi` is driven 1 while still selected for HALF_CYC cycles, and only then does the block deselect and pulse `done`.
- R10: `req_op` is encoded 0 read, 1 write, 2 enable, 3 disable. `req_ack` is high only while idle with `req_valid` high, one operation runs at a time, and `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request, held until acknowledged |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 enable, 3 disable |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Word to write |
| req_ack | output | 1 | Request accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| done_rej | output | 1 | With done: write refused, writes disabled |
| rd_data | output | 16 | Word returned by the last read |
| wr_enabled | output | 1 | Tracked write permission of the target |
| cs_n | output | 1 | Target select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data toward the target |
| miso | input | 1 | Serial data and status from the target |

## Verification
The assertions assume that `req_op`, `req_addr` and `req_wdata` stay steady while `req_valid` waits for `req_ack`. They also assume `miso` is a clean logic level that the target changes only after a falling `sclk` or while it is selected without clocking, so each sample point sees a settled bit. The bench's target model moves `miso` on the half cycle after it sees a falling clock or a change in busy state. It answers a poll only while selected with no frame in progress, and the bench holds every request field until acknowledgement.

// File: rtl/wmh_pkg.sv
package wmh_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_WREN  = 2'd2,
      OP_WRDIS = 2'd3
   } wmh_op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_GAP, ST_LO, ST_HI, ST_END,
      ST_PGAP, ST_PWAIT, ST_REL, ST_FIN
   } wmh_state_e;

   localparam logic [3:0] LEAD    = 4'b1010;
   localparam int         WORD_W  = 16;
   localparam int         FIELD_W = 8;
   localparam int         FRAME_W = 4 + 4 + FIELD_W + WORD_W;
   localparam int         CNT_W   = $clog2(FRAME_W + 1);

   function automatic logic [3:0] op_code(input wmh_op_e op);
      case (op)
         OP_READ:  return 4'b1000;
         OP_WRITE: return 4'b0100;
         OP_WREN:  return 4'b0011;
         default:  return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/wmh_timer.sv
module wmh_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/wmh_frame.sv
module wmh_frame
   import wmh_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [1:0]                 op,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [WORD_W-1:0]          wdata,
   output logic [FRAME_W-1:0]         frame,
   output logic [CNT_W-1:0]           nbits
);
   logic [FIELD_W-1:0] field;
   wmh_op_e            op_e;

   assign op_e = wmh_op_e'(op);

   generate
      if (ADDR_W < 1 || ADDR_W > FIELD_W) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and the address field width");
      end
      if (ADDR_W == FIELD_W) begin : g_full
         assign field = addr;
      end else begin : g_pad
         assign field = {addr, {(FIELD_W - ADDR_W){1'b0}}};
      end
   endgenerate

   assign frame = {LEAD, op_code(op_e), field,
                   (op_e == OP_WRITE) ? wdata : {WORD_W{1'b0}}};
   assign nbits = (op_e == OP_READ || op_e == OP_WRITE) ? CNT_W'(FRAME_W)
                                                        : CNT_W'(FRAME_W - WORD_W);
endmodule

// File: rtl/wordmem_host.sv
module wordmem_host
   import wmh_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int HALF_CYC = 25,
   parameter int CSH_CYC  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              req_ack,
   output logic              done,
   output logic              done_rej,
   output logic [15:0]       rd_data,
   output logic              wr_enabled,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int LD_MAX = (HALF_CYC > CSH_CYC) ? HALF_CYC : CSH_CYC;
   localparam int TMR_W  = $clog2(LD_MAX + 1);
   localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(HALF_CYC - 1);
   localparam logic [TMR_W-1:0] CSH_LD  = TMR_W'(CSH_CYC - 1);
   localparam logic [CNT_W-1:0] CAP_FROM = CNT_W'(FRAME_W - WORD_W);

   generate
      if (HALF_CYC < 3) begin : g_bad_half
         $error("HALF_CYC must be at least 3");
      end
      if (CSH_CYC < 1) begin : g_bad_csh
         $error("CSH_CYC must be at least 1");
      end
   endgenerate

   wmh_state_e          state, state_n;
   wmh_op_e             op_q;
   logic                rej_q;
   logic [FRAME_W-1:0]  tx_q;
   logic [WORD_W-1:0]   rx_q;
   logic [CNT_W-1:0]    bitn, nbits_q;
   logic                wr_en_q;
   logic                tmr_load, tmr_exp;
   logic [TMR_W-1:0]    tmr_val;
   logic [FRAME_W-1:0]  frame_w;
   logic [CNT_W-1:0]    nbits_w;
   logic                write_blocked, last_bit;

   wmh_frame #(.ADDR_W(ADDR_W)) u_frame (
      .op(req_op), .addr(req_addr), .wdata(req_wdata),
      .frame(frame_w), .nbits(nbits_w)
   );

   wmh_timer #(.W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load),
      .load_val(tmr_val), .expired(tmr_exp)
   );

   assign write_blocked = (wmh_op_e'(req_op) == OP_WRITE) && !wr_en_q;
   assign last_bit      = (bitn == nbits_q - 1'b1);

   always_comb begin
      state_n  = state;
      tmr_load = 1'b0;
      tmr_val  = HALF_LD;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            if (write_blocked) state_n = ST_FIN;
            else begin
               state_n  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = CSH_LD;
            end
         end
         ST_GAP: if (tmr_exp) begin
            state_n  = ST_LO;
            tmr_load = 1'b1;
         end
         ST_LO: if (tmr_exp) begin
            state_n  = ST_HI;
            tmr_load = 1'b1;
         end
         ST_HI: if (tmr_exp) begin
            state_n  = last_bit ? ST_END : ST_LO;
            tmr_load = 1'b1;
         end
         ST_END: if (tmr_exp) begin
            if (op_q == OP_WRITE) begin
               state_n  = ST_PGAP;
               tmr_load = 1'b1;
               tmr_val  = CSH_LD;
            end else begin
               state_n = ST_FIN;
            end
         end
         ST_PGAP: if (tmr_exp) begin
            state_n  = ST_PWAIT;
            tmr_load = 1'b1;
         end
         ST_PWAIT: if (tmr_exp) begin
            tmr_load = 1'b1;
            if (miso) state_n = ST_REL;
         end
         ST_REL: if (tmr_exp) state_n = ST_FIN;
         ST_FIN:  state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_READ;
         rej_q   <= 1'b0;
         tx_q    <= '0;
         rx_q    <= '0;
         bitn    <= '0;
         nbits_q <= '0;
         wr_en_q <= 1'b0;
         rd_data <= '0;
      end else begin
         state <= state_n;
         if (state == ST_IDLE && req_valid) begin
            op_q    <= wmh_op_e'(req_op);
            rej_q   <= write_blocked;
            tx_q    <= frame_w;
            nbits_q <= nbits_w;
            bitn    <= '0;
         end
         if (state == ST_HI && tmr_exp) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (op_q == OP_READ && bitn >= CAP_FROM)
               rx_q <= {rx_q[WORD_W-2:0], miso};
         end
         if (state == ST_END && tmr_exp && op_q == OP_READ)
            rd_data <= rx_q;
         if (state == ST_FIN && !rej_q) begin
            if (op_q == OP_WREN)  wr_en_q <= 1'b1;
            if (op_q == OP_WRDIS) wr_en_q <= 1'b0;
         end
      end
   end

   // Pin drivers follow the state register by one cycle, all alike.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n <= 1'b1;
         sclk <= 1'b0;
         mosi <= 1'b0;
      end else begin
         cs_n <= !(state inside {ST_LO, ST_HI, ST_END, ST_PWAIT, ST_REL});
         sclk <= (state == ST_HI);
         if (state == ST_REL)                          mosi <= 1'b1;
         else if (state inside {ST_LO, ST_HI, ST_END}) mosi <= tx_q[FRAME_W-1];
         else                                          mosi <= 1'b0;
      end
   end

   assign req_ack    = (state == ST_IDLE) && req_valid;
   assign done       = (state == ST_FIN);
   assign done_rej   = (state == ST_FIN) && rej_q;
   assign wr_enabled = wr_en_q;

   // ---------------- checks ----------------
   localparam int SKR_W = $clog2(HALF_CYC + 1);
   localparam int CSR_W = $clog2(CSH_CYC + 1);
   localparam logic [SKR_W-1:0] SKR_MAX = SKR_W'(HALF_CYC);
   localparam logic [CSR_W-1:0] CSR_MAX = CSR_W'(CSH_CYC);
   logic [SKR_W-1:0] sk_run;
   logic [CSR_W-1:0] cs_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sk_run <= '0;
         cs_run <= '0;
      end else begin
         if (!sclk)                  sk_run <= '0;
         else if (sk_run != SKR_MAX) sk_run <= sk_run + 1'b1;
         if (!cs_n)                  cs_run <= '0;
         else if (cs_run != CSR_MAX) cs_run <= cs_run + 1'b1;
      end
   end

   p_sk_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (sk_run == SKR_MAX));
   p_mosi_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));
   p_sk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (cs_run == CSR_MAX));
   p_wren_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(wr_enabled));
   p_write_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LO && op_q == OP_WRITE) |-> wr_en_q);
   p_rej_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_rej |-> (cs_n && done));
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/wordmem_host_bench.sv
module wordmem_host_bench;
   localparam int AW = 4, HALF = 25, CSH = 13;
   localparam int MIN_PH = 20, MIN_PER = 50, MIN_CSH = 13, BUSY = 300;

   logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
   logic [1:0] req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic req_ack, done, done_rej, wr_enabled, cs_n, sclk, mosi;
   logic [15:0] rd_data;
   logic miso_r = 1'b0;

   always #10 clk = ~clk;

   wordmem_host #(.ADDR_W(AW), .HALF_CYC(HALF), .CSH_CYC(CSH)) u_wordmem_host (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .done(done), .done_rej(done_rej), .rd_data(rd_data),
      .wr_enabled(wr_enabled), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso_r)
   );

   int checks = 0, fails = 0, cyc = 0, acks = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] wd(input int a);
      return 16'(a * 4951) ^ 16'hC3A5;
   endfunction

   // ---------- target model and pin monitors ----------
   logic [15:0] mem [16];
   int bits = 0, busy = 0, frames = 0, last_bits = 0, released = 0;
   logic [31:0] sh = '0;
   logic [3:0] m_start = '0, m_op = '0, pend_a = '0;
   logic [7:0] m_field = '0;
   logic [15:0] rd_word = '0, pend_d = '0;
   bit reading = 0, m_we = 0, post_wr = 0;
   logic cs_p = 1'b1, sk_p = 1'b0, mosi_p = 1'b0;
   int hi_len = 0, lo_len = 0, rise_gap = 0, cs_hi_len = 0, rises = 0;
   bit have_rise = 0;
   int viol_r2 = 0, viol_r3 = 0, viol_r4 = 0;

   always @(posedge clk) begin
      cyc++;
      if (req_ack) acks++;
      if (cyc == 190000) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (busy > 0) begin
         busy = busy - 1;
         if (busy == 0) mem[pend_a] = pend_d;
      end
      if (!cs_n) begin
         if (sclk && !sk_p) begin
            sh = {sh[30:0], mosi};
            bits++;
            if (bits == 16) begin
               m_start = sh[15:12]; m_op = sh[11:8]; m_field = sh[7:0];
               if (m_op == 4'b1000) begin rd_word = mem[sh[7:4]]; reading = 1; end
               if (m_op == 4'b0011) m_we = 1;
               if (m_op == 4'b0000) m_we = 0;
            end
            if (bits == 32 && m_op == 4'b0100 && m_we) begin
               pend_a = m_field[7:4]; pend_d = sh[15:0]; busy = BUSY; post_wr = 1;
            end
         end
         if (!sclk && sk_p && reading && bits >= 16 && bits < 32)
            miso_r = rd_word[31 - bits];
         if (post_wr && bits == 0) begin
            if (busy == 0 && mosi && !mosi_p) begin
               post_wr = 0; released++; miso_r = 1'b0;
            end else miso_r = (busy == 0);
         end
      end else begin
         if (!cs_p && bits > 0) begin frames++; last_bits = bits; end
         bits = 0; reading = 0; have_rise = 0;
      end
      // timing monitors
      if (sclk && mosi != mosi_p) viol_r3++;
      if (cs_n && sclk) viol_r4++;
      if (cs_n) cs_hi_len++;
      else if (cs_p) begin
         if (cs_hi_len < MIN_CSH) viol_r4++;
         cs_hi_len = 0;
      end
      rise_gap++;
      if (sclk != sk_p) begin
         if (sclk) begin
            rises++;
            if (lo_len < MIN_PH) viol_r2++;
            if (have_rise && rise_gap < MIN_PER) viol_r2++;
            have_rise = 1; rise_gap = 0; lo_len = 0; hi_len = 1;
         end else begin
            if (hi_len < MIN_PH) viol_r2++;
            hi_len = 0; lo_len = 1;
         end
      end else if (sclk) hi_len++;
      else lo_len++;
      cs_p = cs_n; sk_p = sclk; mosi_p = mosi;
   end

   logic [15:0] got_rd;
   bit got_rej;

   task automatic run_op(input int op, input int addr, input logic [15:0] wdat);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr); req_wdata = wdat;
      #1;
      while (!req_ack) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      got_rd = rd_data; got_rej = done_rej;
      @(negedge clk);
      chk(done == 1'b0, "R10 done single pulse", done, 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   int f0, r0;

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (5) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0, "R4 reset pins", {cs_n, sclk}, 2'b10);
      chk(wr_enabled == 1'b0, "R6 reset permission", wr_enabled, 0);
      chk(done == 1'b0 && req_ack == 1'b0, "R10 reset handshake", {done, req_ack}, 0);
      rst_n = 1'b1;

      // R7: write refused before enable
      f0 = frames;
      run_op(1, 3, 16'hBEEF);
      chk(got_rej == 1'b1, "R7 refused write flagged", got_rej, 1);
      chk(frames == f0, "R7 no frame sent", frames, f0);
      chk(mem[3] == 16'h0, "R7 memory untouched", mem[3], 0);

      // R6/R1: enable
      run_op(2, 0, 16'h0);
      chk(wr_enabled == 1'b1, "R6 enabled after enable op", wr_enabled, 1);
      chk(m_start == 4'b1010 && m_op == 4'b0011 && last_bits == 16,
          "R1 enable frame", {m_start, m_op, 8'(last_bits)}, {4'b1010, 4'b0011, 8'd16});

      // R8/R9/R1: write sweep over all addresses
      for (int a = 0; a < 16; a++) begin
         r0 = released;
         run_op(1, a, wd(a));
         chk(got_rej == 1'b0 && m_start == 4'b1010 && m_op == 4'b0100 &&
             m_field == 8'(a << 4) && last_bits == 32, "R1 write frame",
             {m_op, m_field, 8'(last_bits)}, {4'b0100, 8'(a << 4), 8'd32});
         chk(mem[a] == wd(a) && busy == 0, "R8 write done after ready", mem[a], wd(a));
         chk(released == r0 + 1 && !post_wr, "R9 release after ready", released, r0 + 1);
      end

      // R5/R1: read sweep
      for (int a = 0; a < 16; a++) begin
         run_op(0, a, 16'hFFFF);
         chk(got_rd == wd(a), "R5 read word", got_rd, wd(a));
         chk(m_op == 4'b1000 && m_field == 8'(a << 4) && last_bits == 32,
             "R1 read frame", {m_op, m_field, 8'(last_bits)}, {4'b1000, 8'(a << 4), 8'd32});
      end

      // R6: disable, then R7 refusal keeps data
      run_op(3, 0, 16'h0);
      chk(wr_enabled == 1'b0, "R6 cleared after disable op", wr_enabled, 0);
      chk(m_op == 4'b0000 && last_bits == 16, "R1 disable frame", {m_op, 8'(last_bits)}, {4'b0000, 8'd16});
      f0 = frames;
      run_op(1, 5, 16'h1234);
      chk(got_rej == 1'b1 && frames == f0, "R7 refused after disable", frames, f0);
      run_op(0, 5, 16'h0);
      chk(got_rd == wd(5), "R7 word kept after refused write", got_rd, wd(5));

      chk(acks == 37, "R10 one ack per operation", acks, 37);
      chk(viol_r2 == 0 && rises > 0, "R2 clock phase and period limits", viol_r2, 0);
      chk(viol_r3 == 0, "R3 data steady while clock high", viol_r3, 0);
      chk(viol_r4 == 0, "R4 deselect gap and idle clock", viol_r4, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule